// File: doc/BRIEF.md
# Dual Concatenable Down-Counting Timer

This peripheral holds two 32-bit down counters, lane A and lane B, that run from a shared prescaled tick strobe. Each lane counts one step per tick while enabled. When a tick arrives while the count is zero, the lane expires. An expiry sets a sticky raw interrupt flag. The lane then either reloads from its background reload value (periodic) or parks at zero and drops its enable (one-shot). Software clears the flag by writing 1 to it. Each lane drives its own interrupt output, which is the raw flag gated by an interrupt-enable bit.

A mode register joins the two lanes into one 64-bit down counter. Lane A holds the low half and lane B the high half. The joined counter has its own control and status registers and its own load and reload words. The two register banks exclude each other: writes to the bank of the inactive mode are dropped. A read of the joined low value word captures the high half at the same moment, so the two halves can be read as one coherent 64-bit value.

The bus is a simple single-master word interface. A write takes effect at the clock edge. Read data is combinational from the address during a read strobe.

Top module: `dtmr_dual_timer`

## Requirements
- R1: While a lane is enabled (control bit 0) and separate mode is active, each cycle with `tick` high lowers a nonzero count by exactly one. Cycles without `tick` leave the count unchanged.
- R2: A write to a lane's load word (offset 1) places the data in the counter at that edge. A write to the background reload word (offset 2) changes only the reload value, and reads of offset 1 or 2 both return the reload value.
- R3: A tick seen while an enabled periodic lane holds zero is an expiry. It reloads the lane from its background reload value, so the period is reload+1 ticks.
- R4: In one-shot mode (control bit 1), an expiry leaves the count at zero and clears the enable bit. Control bit 2 is interrupt enable, and the control register reads back these three bits.
- R5: An expiry sets the raw flag (offset 4, bit 0). The flag holds until a write with bit 0 set to that word. If an expiry and a clear land in the same cycle, the flag stays set.
- R6: The masked status word (offset 5) and the interrupt output both equal the raw flag ANDed with interrupt enable.
- R7: Writing bit 0 of the mode word (address 0x10) selects joined mode, and writing 0 returns to separate lanes. In joined mode, {lane B, lane A} counts down as one 64-bit value: lane A wraps to all ones and borrows from lane B when it passes zero. Expiry and reload behave as in R3 to R5, using the joined control (0x17), raw (0x18) and masked (0x19) words.
- R8: In joined mode, writes to addresses 0x00 to 0x0F change nothing. In separate mode, writes to 0x11 to 0x19 change nothing. The mode word is always writable.
- R9: A read of the joined low value word (0x16) returns lane A and captures lane B at the same edge. Later reads of the joined high value word (0x15) return the captured half.
- R10: In joined mode, `irq_a` carries the joined masked status and `irq_b` stays low.
- R11: After reset, all counters, reload values, control bits, flags and the mode bit are zero. Lane A's bank sits at 0x00 to 0x05 and lane B's at 0x08 to 0x0D. Joined load words are 0x11 (high) and 0x12 (low), and joined reload words are 0x13 (high) and 0x14 (low). Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled count strobe, one cycle per count |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (triggers the high-half capture) |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data, combinational |
| irq_a | output | 1 | Lane A interrupt, or joined interrupt in joined mode |
| irq_b | output | 1 | Lane B interrupt, low in joined mode |

## Verification
The bench builds the block with its default half width W = 32, so the joined counter is a full 64 bits. Load and reload values kept below 8 make expiries, periodic reloads and one-shot stops occur every few ticks. A joined load with a zero low word reaches the borrow into the high half and the all-ones wrap on the very first tick. Random mode toggles interleaved with writes to both banks exercise the exclusion between banks in both directions, and reads of the low value word exercise the capture of the high half.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  typedef struct packed {
    logic ie;
    logic oneshot;
    logic en;
  } ctl_t;

  localparam int unsigned AW = 5;

  localparam logic [2:0] OF_VAL = 3'd0;
  localparam logic [2:0] OF_LD  = 3'd1;
  localparam logic [2:0] OF_BG  = 3'd2;
  localparam logic [2:0] OF_CTL = 3'd3;
  localparam logic [2:0] OF_RAW = 3'd4;
  localparam logic [2:0] OF_MSK = 3'd5;

  localparam logic [AW-1:0] J_MODE  = 5'h10;
  localparam logic [AW-1:0] J_LDHI  = 5'h11;
  localparam logic [AW-1:0] J_LDLO  = 5'h12;
  localparam logic [AW-1:0] J_BGHI  = 5'h13;
  localparam logic [AW-1:0] J_BGLO  = 5'h14;
  localparam logic [AW-1:0] J_VALHI = 5'h15;
  localparam logic [AW-1:0] J_VALLO = 5'h16;
  localparam logic [AW-1:0] J_CTL   = 5'h17;
  localparam logic [AW-1:0] J_RAW   = 5'h18;
  localparam logic [AW-1:0] J_MSK   = 5'h19;
endpackage

// File: rtl/dtmr_flags.sv
module dtmr_flags
  import dtmr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_we,
  input  ctl_t ctl_wdata,
  input  logic raw_clr,
  input  logic expire,
  output ctl_t ctl_o,
  output logic raw_o,
  output logic irq_o
);
  ctl_t ctl_q, ctl_d;
  logic raw_q, raw_d;

  always_comb begin
    ctl_d = ctl_q;
    if (expire && ctl_q.oneshot) ctl_d.en = 1'b0;
    if (ctl_we) ctl_d = ctl_wdata;
    raw_d = raw_q;
    if (raw_clr) raw_d = 1'b0;
    if (expire) raw_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      raw_q <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      raw_q <= raw_d;
    end
  end

  assign ctl_o = ctl_q;
  assign raw_o = raw_q;
  assign irq_o = raw_q & ctl_q.ie;

  // R4: one-shot expiry drops enable
  a_r4_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
    expire && ctl_q.oneshot && !ctl_we |=> !ctl_q.en);
  // R5: raw flag is sticky without a clear
  a_r5_raw_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    raw_q && !raw_clr |=> raw_q);
  // R5: set wins over clear
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> raw_q);
endmodule

// File: rtl/dtmr_core.sv
module dtmr_core #(
  parameter int unsigned W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              joined,
  input  logic [1:0]        run,
  input  logic [1:0]        osh,
  input  logic              run64,
  input  logic              osh64,
  input  logic [1:0]        ld_we,
  input  logic [1:0]        bg_we,
  input  logic [W-1:0]      wdata,
  output logic [1:0][W-1:0] cnt_o,
  output logic [1:0][W-1:0] bg_o,
  output logic [1:0]        exp_o,
  output logic              exp64_o
);
  localparam int unsigned WW = 2 * W;
  localparam logic [W-1:0]  ONE   = {{(W-1){1'b0}}, 1'b1};
  localparam logic [WW-1:0] ONE64 = {{(WW-1){1'b0}}, 1'b1};

  logic [1:0][W-1:0] cnt_q, cnt_d, bg_q, bg_d;
  logic [WW-1:0]     wide_q, wide_bg, wide_n;
  logic              step64;

  assign wide_q  = {cnt_q[1], cnt_q[0]};
  assign wide_bg = {bg_q[1], bg_q[0]};
  assign step64  = tick && run64 && joined;
  assign exp64_o = step64 && (wide_q == '0);

  for (genvar i = 0; i < 2; i++) begin : g_lane
    assign exp_o[i] = tick && run[i] && !joined && (cnt_q[i] == '0);

    // R1: one step down per tick on a nonzero lane
    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
      !joined && tick && run[i] && (cnt_q[i] != '0) && !ld_we[i]
      |=> cnt_q[i] == $past(cnt_q[i]) - ONE);
    // R3: periodic expiry reloads
    a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
      !joined && tick && run[i] && !osh[i] && (cnt_q[i] == '0) && !ld_we[i] && !bg_we[i]
      |=> cnt_q[i] == bg_q[i]);
  end

  always_comb begin
    if (wide_q == '0) wide_n = osh64 ? wide_q : wide_bg;
    else              wide_n = wide_q - ONE64;
  end

  always_comb begin
    cnt_d = cnt_q;
    bg_d  = bg_q;
    if (joined) begin
      if (step64) begin
        cnt_d[1] = wide_n[WW-1:W];
        cnt_d[0] = wide_n[W-1:0];
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (tick && run[i]) begin
          if (cnt_q[i] == '0) cnt_d[i] = osh[i] ? cnt_q[i] : bg_q[i];
          else                cnt_d[i] = cnt_q[i] - ONE;
        end
      end
    end
    for (int i = 0; i < 2; i++) begin
      if (ld_we[i]) cnt_d[i] = wdata;
      if (bg_we[i]) bg_d[i]  = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      bg_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      bg_q  <= bg_d;
    end
  end

  assign cnt_o = cnt_q;
  assign bg_o  = bg_q;

  // R7: low half wraps and borrows from the high half
  a_r7_borrow: assert property (@(posedge clk) disable iff (!rst_n)
    step64 && (cnt_q[0] == '0) && (cnt_q[1] != '0) && (ld_we == 2'b00)
    |=> (cnt_q[0] == '1) && (cnt_q[1] == $past(cnt_q[1]) - ONE));
  // R1: no tick, no change
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && (ld_we == 2'b00) |=> $stable(cnt_q));
endmodule

// File: rtl/dtmr_dual_timer.sv
module dtmr_dual_timer
  import dtmr_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic          irq_a,
  output logic          irq_b
);
  localparam int unsigned PADW = W - 3;

  logic       rs_meta, rs_n;
  logic       joined_q, joined_d;
  logic [W-1:0] snap_q, snap_d;

  logic [1:0]        ld_we, bg_we, ctl_we, clr, exp_l, irq_l, raw_l;
  logic [1:0]        run, osh;
  ctl_t [1:0]        ctl_l;
  ctl_t              ctl_j;
  logic              raw_j, irq_j, exp_j, ctl_we_j, clr_j;
  logic [1:0][W-1:0] cnt, bg;
  logic              wr32, wr64, lane;
  logic [2:0]        ofs;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  assign lane = bus_addr[3];
  assign ofs  = bus_addr[2:0];
  assign wr32 = bus_wr && !joined_q && !bus_addr[4];
  assign wr64 = bus_wr && joined_q && bus_addr[4];

  for (genvar i = 0; i < 2; i++) begin : g_dec
    assign ld_we[i]  = (wr32 && (lane == i[0]) && (ofs == OF_LD)) ||
                       (wr64 && (bus_addr == (i == 0 ? J_LDLO : J_LDHI)));
    assign bg_we[i]  = (wr32 && (lane == i[0]) && (ofs == OF_BG)) ||
                       (wr64 && (bus_addr == (i == 0 ? J_BGLO : J_BGHI)));
    assign ctl_we[i] = wr32 && (lane == i[0]) && (ofs == OF_CTL);
    assign clr[i]    = wr32 && (lane == i[0]) && (ofs == OF_RAW) && bus_wdata[0];
    assign run[i]    = ctl_l[i].en && !joined_q;
    assign osh[i]    = ctl_l[i].oneshot;

    dtmr_flags u_flags (
      .clk(clk), .rst_n(rs_n), .ctl_we(ctl_we[i]), .ctl_wdata(ctl_t'(bus_wdata[2:0])),
      .raw_clr(clr[i]), .expire(exp_l[i]), .ctl_o(ctl_l[i]), .raw_o(raw_l[i]), .irq_o(irq_l[i])
    );
  end

  assign ctl_we_j = wr64 && (bus_addr == J_CTL);
  assign clr_j    = wr64 && (bus_addr == J_RAW) && bus_wdata[0];

  dtmr_flags u_flags_j (
    .clk(clk), .rst_n(rs_n), .ctl_we(ctl_we_j), .ctl_wdata(ctl_t'(bus_wdata[2:0])),
    .raw_clr(clr_j), .expire(exp_j), .ctl_o(ctl_j), .raw_o(raw_j), .irq_o(irq_j)
  );

  dtmr_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rs_n), .tick(tick), .joined(joined_q),
    .run(run), .osh(osh), .run64(ctl_j.en && joined_q), .osh64(ctl_j.oneshot),
    .ld_we(ld_we), .bg_we(bg_we), .wdata(bus_wdata),
    .cnt_o(cnt), .bg_o(bg), .exp_o(exp_l), .exp64_o(exp_j)
  );

  always_comb begin
    joined_d = joined_q;
    if (bus_wr && (bus_addr == J_MODE)) joined_d = bus_wdata[0];
    snap_d = snap_q;
    if (bus_rd && (bus_addr == J_VALLO)) snap_d = cnt[1];
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      joined_q <= 1'b0;
      snap_q   <= '0;
    end else begin
      joined_q <= joined_d;
      snap_q   <= snap_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (!bus_addr[4]) begin
      case (ofs)
        OF_VAL:        bus_rdata = cnt[lane];
        OF_LD, OF_BG:  bus_rdata = bg[lane];
        OF_CTL:        bus_rdata = {{PADW{1'b0}}, ctl_l[lane]};
        OF_RAW:        bus_rdata = {{(W-1){1'b0}}, raw_l[lane]};
        OF_MSK:        bus_rdata = {{(W-1){1'b0}}, irq_l[lane]};
        default:       bus_rdata = '0;
      endcase
    end else begin
      case (bus_addr)
        J_MODE:          bus_rdata = {{(W-1){1'b0}}, joined_q};
        J_LDHI, J_BGHI:  bus_rdata = bg[1];
        J_LDLO, J_BGLO:  bus_rdata = bg[0];
        J_VALHI:         bus_rdata = snap_q;
        J_VALLO:         bus_rdata = cnt[0];
        J_CTL:           bus_rdata = {{PADW{1'b0}}, ctl_j};
        J_RAW:           bus_rdata = {{(W-1){1'b0}}, raw_j};
        J_MSK:           bus_rdata = {{(W-1){1'b0}}, irq_j};
        default:         bus_rdata = '0;
      endcase
    end
  end

  assign irq_a = joined_q ? irq_j : irq_l[0];
  assign irq_b = joined_q ? 1'b0 : irq_l[1];

  // R8: lane control frozen against writes while joined
  a_r8_lane_locked: assert property (@(posedge clk) disable iff (!rs_n)
    joined_q && bus_wr && !bus_addr[4] |=> $stable(ctl_l));
  // R8: joined control frozen against writes while separate
  a_r8_joined_locked: assert property (@(posedge clk) disable iff (!rs_n)
    !joined_q && bus_wr && (bus_addr == J_CTL) |=> $stable(ctl_j));
  // R9: capture of the high half on a low-word read
  a_r9_snapshot: assert property (@(posedge clk) disable iff (!rs_n)
    bus_rd && (bus_addr == J_VALLO) |=> snap_q == $past(cnt[1]));
  // R10: lane B interrupt silent while joined
  a_r10_irq_b_quiet: assert property (@(posedge clk) disable iff (!rs_n)
    joined_q && !(bus_wr && (bus_addr == J_MODE)) |=> !irq_b);
endmodule

// File: tb/dtmr_dual_timer_test.sv
module dtmr_dual_timer_test;
  localparam int unsigned W = 32;
  localparam int unsigned WD_CYCLES = 200000;

  logic clk, rst_n, tick, bus_wr, bus_rd;
  logic [4:0] bus_addr;
  logic [W-1:0] bus_wdata, bus_rdata;
  logic irq_a, irq_b;

  int checks = 0;
  int failures = 0;

  // model state
  logic [W-1:0] m_cnt [2];
  logic [W-1:0] m_bg [2];
  logic [2:0]   m_ctl [3];
  logic         m_raw [3];
  logic         m_j;
  logic [W-1:0] m_snap;

  dtmr_dual_timer #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_a(irq_a), .irq_b(irq_b)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [4:0] a);
    if (!a[4]) begin
      case (a[2:0])
        3'd0: return "R1 R3 value";
        3'd1, 3'd2: return "R2 reload";
        3'd3: return "R4 control";
        3'd4: return "R5 raw";
        3'd5: return "R6 masked";
        default: return "R11 unmapped";
      endcase
    end
    case (a)
      5'h10: return "R8 mode";
      5'h11, 5'h12, 5'h13, 5'h14: return "R7 joined reload";
      5'h15: return "R9 snapshot";
      5'h16: return "R7 joined low";
      5'h17: return "R4 joined control";
      5'h18: return "R5 joined raw";
      5'h19: return "R6 joined masked";
      default: return "R11 unmapped";
    endcase
  endfunction

  function automatic logic [W-1:0] m_read(input logic [4:0] a);
    int l;
    l = a[3] ? 1 : 0;
    if (!a[4]) begin
      case (a[2:0])
        3'd0: return m_cnt[l];
        3'd1, 3'd2: return m_bg[l];
        3'd3: return {{(W-3){1'b0}}, m_ctl[l]};
        3'd4: return {{(W-1){1'b0}}, m_raw[l]};
        3'd5: return {{(W-1){1'b0}}, m_raw[l] & m_ctl[l][2]};
        default: return '0;
      endcase
    end
    case (a)
      5'h10: return {{(W-1){1'b0}}, m_j};
      5'h11, 5'h13: return m_bg[1];
      5'h12, 5'h14: return m_bg[0];
      5'h15: return m_snap;
      5'h16: return m_cnt[0];
      5'h17: return {{(W-3){1'b0}}, m_ctl[2]};
      5'h18: return {{(W-1){1'b0}}, m_raw[2]};
      5'h19: return {{(W-1){1'b0}}, m_raw[2] & m_ctl[2][2]};
      default: return '0;
    endcase
  endfunction

  task automatic m_step(input logic wr, input logic rd, input logic [4:0] a,
                        input logic [W-1:0] d, input logic tk);
    logic [W-1:0] nc [2];
    logic [2*W-1:0] w;
    logic ex [3];
    bit w32, w64;
    int l;
    l = a[3] ? 1 : 0;
    w32 = wr && !m_j && !a[4];
    w64 = wr && m_j && a[4];
    nc[0] = m_cnt[0];
    nc[1] = m_cnt[1];
    w = {m_cnt[1], m_cnt[0]};
    ex[2] = tk && m_j && m_ctl[2][0] && (w == '0);
    for (int i = 0; i < 2; i++) ex[i] = tk && !m_j && m_ctl[i][0] && (m_cnt[i] == '0);
    if (m_j) begin
      if (tk && m_ctl[2][0]) begin
        if (w == '0) w = m_ctl[2][1] ? w : {m_bg[1], m_bg[0]};
        else w = w - 1;
        nc[1] = w[2*W-1:W];
        nc[0] = w[W-1:0];
      end
    end else begin
      for (int i = 0; i < 2; i++)
        if (tk && m_ctl[i][0]) begin
          if (m_cnt[i] == '0) nc[i] = m_ctl[i][1] ? m_cnt[i] : m_bg[i];
          else nc[i] = m_cnt[i] - 1;
        end
    end
    if (rd && a == 5'h16) m_snap = m_cnt[1];
    for (int k = 0; k < 3; k++) if (ex[k] && m_ctl[k][1]) m_ctl[k][0] = 1'b0;
    if (w32) begin
      case (a[2:0])
        3'd1: nc[l] = d;
        3'd2: m_bg[l] = d;
        3'd3: m_ctl[l] = d[2:0];
        3'd4: if (d[0]) m_raw[l] = 1'b0;
        default: ;
      endcase
    end
    if (w64) begin
      case (a)
        5'h11: nc[1] = d;
        5'h12: nc[0] = d;
        5'h13: m_bg[1] = d;
        5'h14: m_bg[0] = d;
        5'h17: m_ctl[2] = d[2:0];
        5'h18: if (d[0]) m_raw[2] = 1'b0;
        default: ;
      endcase
    end
    for (int k = 0; k < 3; k++) if (ex[k]) m_raw[k] = 1'b1;
    if (wr && a == 5'h10) m_j = d[0];
    m_cnt[0] = nc[0];
    m_cnt[1] = nc[1];
  endtask

  task automatic cyc(input logic wr, input logic rd, input logic [4:0] a,
                     input logic [W-1:0] d, input logic tk);
    logic ea, eb;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; tick = tk;
    #1;
    if (rd) chk(req_of(a), bus_rdata, m_read(a));
    ea = m_j ? (m_raw[2] & m_ctl[2][2]) : (m_raw[0] & m_ctl[0][2]);
    eb = m_j ? 1'b0 : (m_raw[1] & m_ctl[1][2]);
    chk("R6 R10 irq", {{(W-2){1'b0}}, irq_a, irq_b}, {{(W-2){1'b0}}, ea, eb});
    @(posedge clk);
    m_step(wr, rd, a, d, tk);
  endtask

  task automatic wr_(input logic [4:0] a, input logic [W-1:0] d);
    cyc(1'b1, 1'b0, a, d, 1'b0);
  endtask
  task automatic rd_(input logic [4:0] a);
    cyc(1'b0, 1'b1, a, '0, 1'b0);
  endtask
  task automatic tk_(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 5'h0, '0, 1'b1);
  endtask

  initial begin
    #(WD_CYCLES * 8);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 2; i++) begin m_cnt[i] = '0; m_bg[i] = '0; end
    for (int k = 0; k < 3; k++) begin m_ctl[k] = '0; m_raw[k] = 1'b0; end
    m_j = 1'b0; m_snap = '0;
    rst_n = 1'b0; tick = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) cyc(1'b0, 1'b0, 5'h0, '0, 1'b0);

    // R11: reset state of every address
    for (int a = 0; a < 32; a++) rd_(5'(a));

    // R1 R2 R3 R5 R6: lane A periodic with interrupt
    wr_(5'h02, 32'd3);
    wr_(5'h01, 32'd2);
    rd_(5'h00);
    wr_(5'h03, 32'd5);
    for (int i = 0; i < 8; i++) begin tk_(1); rd_(5'h00); rd_(5'h04); end
    cyc(1'b0, 1'b0, 5'h0, '0, 1'b0);
    rd_(5'h00);
    wr_(5'h04, 32'd1);
    rd_(5'h04);
    rd_(5'h05);

    // R4: lane B one-shot
    wr_(5'h09, 32'd1);
    wr_(5'h0B, 32'd7);
    tk_(4);
    rd_(5'h08);
    rd_(5'h0B);
    rd_(5'h0C);

    // R7 R9: joined borrow
    wr_(5'h03, 32'd0);
    wr_(5'h10, 32'd1);
    wr_(5'h12, 32'd0);
    wr_(5'h11, 32'd1);
    wr_(5'h17, 32'd1);
    tk_(1);
    rd_(5'h16);
    rd_(5'h15);
    tk_(2);
    rd_(5'h16);
    rd_(5'h15);

    // R8: lane writes ignored while joined
    wr_(5'h09, 32'd5);
    wr_(5'h0B, 32'd7);
    wr_(5'h03, 32'd7);
    rd_(5'h0B);
    rd_(5'h03);
    rd_(5'h0A);
    // R7 R10: joined expiry to irq_a
    wr_(5'h11, 32'd0);
    wr_(5'h12, 32'd1);
    wr_(5'h17, 32'd7);
    tk_(3);
    rd_(5'h17);
    rd_(5'h19);
    // R8: joined writes ignored while separate
    wr_(5'h10, 32'd0);
    wr_(5'h17, 32'd1);
    wr_(5'h14, 32'd9);
    rd_(5'h17);
    rd_(5'h14);

    // random phase
    for (int n = 0; n < 6000; n++) begin
      int op, s;
      logic [4:0] a;
      op = $urandom % 4;
      s = $urandom % 22;
      if (s < 6) a = 5'(s);
      else if (s < 12) a = 5'(s + 2);
      else a = 5'(s + 4);
      cyc(op == 1, op >= 2, a, W'($urandom % 8), 1'($urandom % 2));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule